// File: doc/BRIEF.md
# Real-Time Clock Seconds Counter with Rate Trim

This block is the counting core of a real-time clock. A clock input of nominally 32.768 kHz feeds a prescaler that emits a one-second tick, and each tick advances a 32-bit seconds counter. Oscillator error is corrected by a signed trim. The trim lengthens or shortens one prescaler period, and it is applied once per programmable number of seconds. All other periods keep the nominal length.

Software controls the core through a small word-wide register port with four registers. One register holds the seconds value. One holds the run control and the overflow status. One holds the trim settings. One holds two protection bits. To set the time, software stops the counter, writes the seconds value and restarts the counter. Once a protection bit is cleared, the trim settings, the protection register, or both become read-only until the next reset.

The nominal period is 2**PRESCALE_BITS input cycles. This is 32768 at the default of 15.

Top module: `rtc_core`

## Requirements
- R1: After reset, the seconds register reads 1. The control/status register reads 0. The trim register reads 0. The protection register reads 3.
- R2: With a trim of 0, or outside the first period of an interval, the seconds value rises by one every 2**PRESCALE_BITS input cycles.
- R3: Trim register bits [7:0] hold a signed two's-complement trim T. A trimmed period lasts 2**PRESCALE_BITS - T cycles. So 0x01 gives one cycle fewer, 0x7F gives 127 fewer, 0xFF gives one more and 0x80 gives 128 more. A positive T makes the clock run faster and a negative T makes it run slower.
- R4: Trim register bits [15:8] hold N-1. The trimmed period is the first prescaler period of every run of N seconds, and the other N-1 periods are untrimmed. A value of 0 trims every period and 255 trims one period in 256.
- R5: Control/status bit 0 is the run enable. While it is 0, neither the seconds value nor the prescaler advances.
- R6: A write to the seconds register takes effect only while the run enable is 0. While the run enable is 1, the write is ignored.
- R7: Writing 0 to the seconds register stores 1, because 0 is not a valid time.
- R8: An accepted seconds write clears the prescaler and the interval position. The first tick after re-enable therefore comes one full trimmed period later.
- R9: Protection bit 0 is the trim unlock. While it is 0, writes to the trim register are ignored.
- R10: Protection bit 1 is the protection-register unlock. While it is 0, writes to the protection register are ignored. A write can only clear protection bits, never set them. Only reset sets them again.
- R11: From 0xFFFFFFFF the seconds value wraps to 0 and sets the sticky overflow flag, control/status bit 1. While the flag is set, counting stops. An accepted seconds write clears the flag.
- R12: The register addresses are 0 for seconds, 1 for control/status, 2 for trim and 3 for protection. Read data follows the address combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock, nominally 32.768 kHz |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data for the selected address |

## Verification
The hardest state to reach is the seconds wrap: it needs about four billion ticks. The bench reaches it by stopping the counter, loading 0xFFFFFFFE and restarting. It then checks that the wrap is reached, that the flag is set and that the count stays frozen. The bench uses a shortened prescaler. This keeps every trim extreme and a multi-second interval pattern within a short run. A monitor times each change of the seconds value against a queue of expected period lengths.

// File: rtl/rtc_pkg.sv
// Shared definitions for the real-time clock core: register addresses
// and the trimmed-period arithmetic.
package rtc_pkg;

    localparam logic [1:0] ADDR_SECS   = 2'd0;
    localparam logic [1:0] ADDR_CTRL   = 2'd1;
    localparam logic [1:0] ADDR_TRIM   = 2'd2;
    localparam logic [1:0] ADDR_PROT   = 2'd3;

    typedef struct packed {
        logic [7:0] interval_m1;
        logic [7:0] trim;
    } trim_cfg_t;

    // Last count value of a prescaler period, base length minus signed trim
    function automatic logic [16:0] period_last(input logic [16:0] base,
                                                input logic [7:0]  trim,
                                                input logic        apply);
        logic [16:0] len;
        len = apply ? (base - {{9{trim[7]}}, trim}) : base;
        return len - 17'd1;
    endfunction

endpackage

// File: rtl/rtc_regs.sv
// Register file of the real-time clock core.
// Holds run enable, trim settings and protection bits. Decodes the
// writes to the seconds register and builds the read mux.
// Assumes single-cycle write strobes. Reads are combinational.
module rtc_regs
    import rtc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  addr,
    input  logic [31:0] wr_data,
    input  logic [31:0] secs,
    input  logic        ovf,
    output logic        en,
    output trim_cfg_t   cfg,
    output logic        trim_unlk,
    output logic        prot_unlk,
    output logic        secs_load,
    output logic [31:0] rd_data
);

    // Seconds writes are accepted only while stopped
    assign secs_load = wr_en && (addr == ADDR_SECS) && !en;

    // Run enable register
    always_ff @(posedge clk) begin
        if (!rst_n)
            en <= 1'b0;
        else if (wr_en && addr == ADDR_CTRL)
            en <= wr_data[0];
    end

    // Trim settings, writable only while unlocked
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg <= '0;
        else if (wr_en && addr == ADDR_TRIM && trim_unlk)
            cfg <= trim_cfg_t'(wr_data[15:0]);
    end

    // Protection bits: may only be cleared, and only while unlocked
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trim_unlk <= 1'b1;
            prot_unlk <= 1'b1;
        end else if (wr_en && addr == ADDR_PROT && prot_unlk) begin
            trim_unlk <= trim_unlk & wr_data[0];
            prot_unlk <= prot_unlk & wr_data[1];
        end
    end

    // Read mux
    always_comb begin
        case (addr)
            ADDR_SECS: rd_data = secs;
            ADDR_CTRL: rd_data = {30'd0, ovf, en};
            ADDR_TRIM: rd_data = {16'd0, cfg};
            default:   rd_data = {30'd0, prot_unlk, trim_unlk};
        endcase
    end

endmodule

// File: rtl/rtc_prescaler.sv
// Divides the counting clock to one-second ticks.
// The first period of each interval of (interval_m1+1) seconds is
// lengthened or shortened by the signed trim. Other periods are
// 2**PRESCALE_BITS cycles long.
// Assumes PRESCALE_BITS is between 9 and 16.
module rtc_prescaler
    import rtc_pkg::*;
#(
    parameter int PRESCALE_BITS = 15
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run,
    input  logic      clear,
    input  trim_cfg_t cfg,
    output logic      tick
);

    localparam int          CW   = PRESCALE_BITS + 1;
    localparam logic [16:0] BASE = 17'(1 << PRESCALE_BITS);

    logic [CW-1:0] cnt;
    logic [7:0]    pos;
    logic [16:0]   last;

    // Terminal count for the current period
    always_comb begin
        last = period_last(BASE, cfg.trim, pos == 8'd0);
        tick = run && (cnt == last[CW-1:0]);
    end

    // Prescaler counter
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt <= '0;
        else if (run)
            cnt <= tick ? '0 : cnt + 1'b1;
    end

    // Position of the current second within its trim interval
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            pos <= 8'd0;
        else if (tick)
            pos <= (pos >= cfg.interval_m1) ? 8'd0 : pos + 8'd1;
    end

endmodule

// File: rtl/rtc_seconds.sv
// 32-bit seconds counter with load and sticky overflow flag.
// A load of 0 is stored as 1. Wrapping to 0 sets the flag, and only a
// load clears it.
module rtc_seconds #(
    parameter int SECS_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [SECS_W-1:0] load_val,
    output logic [SECS_W-1:0] secs,
    output logic              ovf
);

    // Seconds value and overflow flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            secs <= SECS_W'(1);
            ovf  <= 1'b0;
        end else if (load) begin
            secs <= (load_val == '0) ? SECS_W'(1) : load_val;
            ovf  <= 1'b0;
        end else if (tick) begin
            secs <= secs + 1'b1;
            if (&secs)
                ovf <= 1'b1;
        end
    end

endmodule

// File: rtl/rtc_core.sv
// Top of the real-time clock core: register file, prescaler with trim,
// and seconds counter. Counting runs while enabled and not overflowed.
module rtc_core
    import rtc_pkg::*;
#(
    parameter int PRESCALE_BITS = 15
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  addr,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data
);

    logic        en;
    logic        ovf;
    logic        tick;
    logic        secs_load;
    logic        trim_unlk;
    logic        prot_unlk;
    logic        run;
    logic [31:0] secs;
    trim_cfg_t   cfg;

    // Counting is allowed while enabled and not overflowed
    assign run = en && !ovf;

    rtc_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wr_data   (wr_data),
        .secs      (secs),
        .ovf       (ovf),
        .en        (en),
        .cfg       (cfg),
        .trim_unlk (trim_unlk),
        .prot_unlk (prot_unlk),
        .secs_load (secs_load),
        .rd_data   (rd_data)
    );

    rtc_prescaler #(.PRESCALE_BITS(PRESCALE_BITS)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .clear (secs_load),
        .cfg   (cfg),
        .tick  (tick)
    );

    rtc_seconds #(.SECS_W(32)) u_secs (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (secs_load),
        .load_val (wr_data),
        .secs     (secs),
        .ovf      (ovf)
    );

endmodule

// File: rtl/rtc_core_chk.sv
// Property checker for rtc_core, attached by bind.
module rtc_core_chk
    import rtc_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [1:0]  addr,
    input logic [31:0] wr_data,
    input logic [31:0] secs,
    input logic        ovf,
    input logic        en,
    input logic        tick,
    input logic        secs_load,
    input logic        trim_unlk,
    input logic        prot_unlk,
    input trim_cfg_t   cfg
);

    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !(wr_en && addr == ADDR_SECS)) |=> $stable(secs)); // R5
    AST_RUN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wr_en && addr == ADDR_SECS && !tick) |=> $stable(secs)); // R6
    AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_SECS && !en && wr_data == 32'd0) |=> secs == 32'd1); // R7
    AST_TRIM_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !trim_unlk |=> $stable(cfg)); // R9
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!trim_unlk || !prot_unlk) |=> ($past(trim_unlk) >= trim_unlk) && ($past(prot_unlk) >= prot_unlk) && !(trim_unlk && prot_unlk)); // R10
    AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && secs == 32'hFFFF_FFFF && !secs_load) |=> (ovf && secs == 32'd0)); // R11
    AST_NO_OVERFLOW_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !secs_load) |=> $stable(secs)); // R11
    AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !secs_load) |=> secs == $past(secs) + 32'd1); // R2

endmodule

bind rtc_core rtc_core_chk u_chk (.*);

// File: tb/tb_rtc_core.sv
// Scoreboard bench: the driver queues expected tick periods, and a
// monitor times each seconds change against them.
module tb_rtc_core;

    localparam int PB   = 10;
    localparam int BASE = 1 << PB;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic [31:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int last_cyc = 0;
    bit armed = 1'b0;
    bit timeout = 1'b0;
    logic [31:0] prev_secs = 32'd1;
    int   exp_q[$];
    string tag_q[$];

    rtc_core #(.PRESCALE_BITS(PB)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: time each seconds change and compare with the queue
    always @(negedge clk) begin
        if (dut.rd_data !== 32'hx && addr == 2'd0) begin end
        if (armed && dut.u_secs.secs != prev_secs) begin
            if (exp_q.size() > 0) begin
                int e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_chk++;
                if (cyc - last_cyc != e) begin
                    n_fail++;
                    $display("FAIL %s period actual %0d expected %0d", t, cyc - last_cyc, e);
                end
            end
            last_cyc = cyc;
        end
        prev_secs = dut.u_secs.secs;
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic chk_rd(input logic [1:0] a, input logic [31:0] e, input string req);
        @(negedge clk);
        addr = a;
        #1;
        n_chk++;
        if (rd_data !== e) begin
            n_fail++;
            $display("FAIL %s addr %0d actual %h expected %h", req, a, rd_data, e);
        end
    endtask

    task automatic push(input int p, input string req);
        exp_q.push_back(p);
        tag_q.push_back(req);
    endtask

    // Load seconds while stopped, then start and time the queued periods
    task automatic run_periods(input logic [31:0] start);
        armed = 1'b0;
        wr(2'd1, 32'd0);
        wr(2'd0, start);
        wr(2'd1, 32'd1);
        last_cyc = cyc;
        armed = 1'b1;
        while (exp_q.size() > 0 && !timeout) @(negedge clk);
        wr(2'd1, 32'd0);
        armed = 1'b0;
    endtask

    initial begin
        #1000000;
        timeout = 1'b1;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        chk_rd(2'd0, 32'd1, "R1");
        chk_rd(2'd1, 32'd0, "R1");
        chk_rd(2'd2, 32'd0, "R1");
        chk_rd(2'd3, 32'd3, "R1");
        // R2 untrimmed period
        repeat (3) push(BASE, "R2");
        run_periods(32'd10);
        chk_rd(2'd0, 32'd13, "R2");
        // R6 write ignored while running, R12 status reads enable
        wr(2'd1, 32'd1);
        wr(2'd0, 32'd500);
        chk_rd(2'd0, 32'd13, "R6");
        chk_rd(2'd1, 32'd1, "R12");
        // R5 stopped counter holds
        wr(2'd1, 32'd0);
        repeat (2500) @(negedge clk);
        chk_rd(2'd0, 32'd13, "R5");
        // R7 zero loads as one
        wr(2'd0, 32'd0);
        chk_rd(2'd0, 32'd1, "R7");
        // R3 trim extremes, interval of one second; R8 full period after load
        wr(2'd2, 32'h0001);
        chk_rd(2'd2, 32'h0001, "R12");
        repeat (2) push(BASE - 1, "R3 R8");
        run_periods(32'd20);
        wr(2'd2, 32'h00FF);
        repeat (2) push(BASE + 1, "R3");
        run_periods(32'd20);
        wr(2'd2, 32'h007F);
        repeat (2) push(BASE - 127, "R3");
        run_periods(32'd20);
        wr(2'd2, 32'h0080);
        repeat (2) push(BASE + 128, "R3");
        run_periods(32'd20);
        // R4 trim once every three seconds
        wr(2'd2, 32'h0201);
        push(BASE - 1, "R4"); push(BASE, "R4"); push(BASE, "R4");
        push(BASE - 1, "R4"); push(BASE, "R4");
        run_periods(32'd40);
        chk_rd(2'd0, 32'd45, "R4");
        // R9 trim lock
        wr(2'd3, 32'd2);
        wr(2'd2, 32'h0055);
        chk_rd(2'd2, 32'h0201, "R9");
        chk_rd(2'd3, 32'd2, "R9");
        // R10 protection lock, no re-set
        wr(2'd3, 32'd0);
        wr(2'd3, 32'd3);
        chk_rd(2'd3, 32'd0, "R10");
        // R11 wrap, sticky flag, frozen count
        push(BASE - 1, "R11");
        push(BASE, "R11");
        armed = 1'b0;
        wr(2'd1, 32'd0);
        wr(2'd0, 32'hFFFF_FFFE);
        wr(2'd1, 32'd1);
        last_cyc = cyc;
        armed = 1'b1;
        while (exp_q.size() > 0 && !timeout) @(negedge clk);
        chk_rd(2'd0, 32'd0, "R11");
        chk_rd(2'd1, 32'd3, "R11");
        repeat (3000) @(negedge clk);
        chk_rd(2'd0, 32'd0, "R11");
        armed = 1'b0;
        wr(2'd1, 32'd0);
        wr(2'd0, 32'd5);
        chk_rd(2'd1, 32'd0, "R11");
        chk_rd(2'd0, 32'd5, "R11");
        if (timeout) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual hung expected done");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog that ends a hung run
    initial begin
        wait (timeout);
        repeat (10) @(negedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual expired expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule